// File: doc/BRIEF.md
# Module Clock and Reset State Controller

This block drives the clock enable and the reset hold of a bank of peripheral modules that share one always-on power domain. Software talks to it over a small memory-mapped register bus. Each module has a control word and a status word.

The control word stages the state that module should reach next. Staging a state does nothing to the module on its own. A single global go command then commits every staged state at once. The sequencer moves every module that must change through a fixed, two-step clock and reset order, then updates all status words together and drops the busy flag.

Each module is always in one of three states:

| Code | State | Clock | Reset |
|------|-------|-------|-------|
| 0 | disabled | off | held |
| 1 | synchronous reset | on | held |
| 3 | enabled | on | released |

The sequencer has four states:

- `SQ_IDLE`: waits. An accepted go moves it to `SQ_LEAD`, and each module's staged target is latched.
- `SQ_LEAD`: the first edge. Clocks turn on and resets assert for the modules that need it. It then moves to `SQ_GAP` and loads the gap counter.
- `SQ_GAP`: counts down. When the counter reaches zero, resets release and clocks gate for the modules that need it, and the sequencer moves to `SQ_COMMIT`.
- `SQ_COMMIT`: copies the targets into the status words and returns to `SQ_IDLE`.

Top module: `modclk_ctrl`

## Requirements
- R1: After a transition, a module whose status reads 0 has its clock off and its reset held. Status 1 means clock on and reset held. Status 3 means clock on and reset released.
- R2: The address map is fixed:
  - 0x00, bit 0: go command.
  - 0x04, bit 0: busy flag.
  - 0x40 + 4*i: control word of module i. The next-state code is in bits 1:0 and the retained flag in bit 9.
  - 0x80 + 4*i: status word of module i. The current state code is in bits 1:0.
  - All other bits read 0. Reads are combinational.
- R3: Writing a control word changes neither the module outputs nor its status word until a go is accepted.
- R4: A write of 1 to bit 0 of 0x00 while idle commits the staged next states of all modules together. Busy reads 1 from the following cycle.
- R5: Busy reads 1 until every module has reached its target. It clears STEP_CYC+2 cycles after the go edge, and at that edge every status word takes the requested state.
- R6: A module whose clock must turn on does so one cycle after the go edge. A reset that must be released is released STEP_CYC cycles later, so the clock always runs before reset release.
- R7: A module whose reset must be asserted has it asserted one cycle after the go edge. A clock that must be gated is gated STEP_CYC cycles later, so reset is always held before the clock stops.
- R8: Bit 9 of a control word is stored and read back independently of the next-state field. It has no effect on the module, so a read-modify-write of the next-state field keeps it.
- R9: Control or status addresses whose module index is MOD_CNT or above are ignored on write and read as 0.
- R10: A go written while busy is set is ignored.
- R11: After reset:
  - every module is disabled, with its clock off and its reset held;
  - every status word reads 0;
  - every control word reads 0;
  - busy is clear.
- R12: A write with next-state code 2, which is not a valid state, leaves the stored next state unchanged. Bit 9 is still written.
- R13: A write to 0x00 with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when set, read when clear |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| mod_clk_en | output | MOD_CNT | Per-module clock enable |
| mod_rst_hold | output | MOD_CNT | Per-module reset, 1 holds the module in reset |

## Verification
The ordering assertions assume that every staged target is one of the three legal codes. The write path guarantees this by refusing code 2, so the stimulus freely writes 2 to exercise that filter. The assertions also assume the bus is only sampled on clock edges, so the stimulus changes the bus signals only on the falling edge.

Busy is polled on every cycle across each transition, including a second go written into the busy window. The stimulus covers both the upward and the downward orderings, and it also writes to out-of-range module indices.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LEAD   = 2'd1,
        SQ_GAP    = 2'd2,
        SQ_COMMIT = 2'd3
    } seq_e;

    // Address map: addr[7:6] selects the area, addr[5:2] selects the slot
    localparam logic [1:0] AREA_GLOB = 2'd0;
    localparam logic [1:0] AREA_CTRL = 2'd1;
    localparam logic [1:0] AREA_STAT = 2'd2;
    localparam logic [3:0] SLOT_GO   = 4'd0;
    localparam logic [3:0] SLOT_BUSY = 4'd1;
    localparam int         KEEP_BIT  = 9;

    // State code bit 0: clock running. State code bit 1: reset released.
    function automatic logic clk_wanted(input logic [1:0] code);
        return code[0];
    endfunction

    function automatic logic hold_wanted(input logic [1:0] code);
        return !code[1];
    endfunction

    function automatic logic code_legal(input logic [1:0] code);
        return code != 2'd2;
    endfunction

endpackage

// File: rtl/mcr_seq.sv
module mcr_seq
    import mcr_pkg::*;
#(
    parameter int STEP_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic go_req,
    output logic launch,
    output logic ph_lead,
    output logic ph_trail,
    output logic commit,
    output logic busy
);

    localparam int CNT_W = $clog2(STEP_CYC + 1);

    seq_e             state_q, state_d;
    logic [CNT_W-1:0] gap_q;

    // State register and gap counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_LEAD) begin
                gap_q <= CNT_W'(STEP_CYC - 1);
            end else if (state_q == SQ_GAP && gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (go_req) state_d = SQ_LEAD;
            SQ_LEAD:   state_d = SQ_GAP;
            SQ_GAP:    if (gap_q == '0) state_d = SQ_COMMIT;
            SQ_COMMIT: state_d = SQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        launch   = (state_q == SQ_IDLE) && go_req;
        ph_lead  = (state_q == SQ_LEAD);
        ph_trail = (state_q == SQ_GAP) && (gap_q == '0);
        commit   = (state_q == SQ_COMMIT);
        busy     = (state_q != SQ_IDLE);
    end

    // R10: a go written while busy must not restart the sequence
    p_go_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_IDLE && go_req) |=> (state_q != SQ_LEAD));

    // R11: reset always leaves the sequencer idle
    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> (state_q == SQ_IDLE));

    // R5: the gap counter never exceeds its load value
    p_gap_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (int'(gap_q) <= STEP_CYC - 1));

endmodule

// File: rtl/mcr_regs.sv
module mcr_regs
    import mcr_pkg::*;
#(
    parameter int MOD_CNT = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_sel,
    input  logic                   bus_we,
    input  logic [7:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    input  logic                   busy,
    input  logic [2*MOD_CNT-1:0]   cur_flat,
    output logic [31:0]            bus_rdata,
    output logic [2*MOD_CNT-1:0]   next_flat,
    output logic                   go_req
);

    logic [1:0] area;
    logic [3:0] slot;
    logic       wr;
    logic       unused_bits;

    assign area        = bus_addr[7:6];
    assign slot        = bus_addr[5:2];
    assign wr          = bus_sel && bus_we;
    assign go_req      = wr && area == AREA_GLOB && slot == SLOT_GO && bus_wdata[0];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:10], bus_wdata[8:2]};

    logic [1:0] next_q [MOD_CNT];
    logic       keep_q [MOD_CNT];

    // One control word per module; indices at or above MOD_CNT never match a slot
    for (genvar i = 0; i < MOD_CNT; i++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst) begin
                next_q[i] <= 2'd0;
                keep_q[i] <= 1'b0;
            end else if (wr && area == AREA_CTRL && slot == 4'(i)) begin
                if (code_legal(bus_wdata[1:0])) next_q[i] <= bus_wdata[1:0];
                keep_q[i] <= bus_wdata[KEEP_BIT];
            end
        end
        assign next_flat[2*i +: 2] = next_q[i];
    end

    // Combinational read mux
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < MOD_CNT; k++) begin
            if (slot == 4'(k)) begin
                if (area == AREA_CTRL) begin
                    bus_rdata[1:0]      = next_q[k];
                    bus_rdata[KEEP_BIT] = keep_q[k];
                end else if (area == AREA_STAT) begin
                    bus_rdata[1:0] = cur_flat[2*k +: 2];
                end
            end
        end
        if (area == AREA_GLOB && slot == SLOT_BUSY) bus_rdata[0] = busy;
    end

endmodule

// File: rtl/mcr_lane.sv
module mcr_lane
    import mcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       launch,
    input  logic       ph_lead,
    input  logic       ph_trail,
    input  logic       commit,
    input  logic       busy,
    input  logic [1:0] next_code,
    output logic       clk_en,
    output logic       rst_hold,
    output logic [1:0] cur_code
);

    logic [1:0] tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q    <= 2'd0;
            clk_en   <= 1'b0;
            rst_hold <= 1'b1;
            cur_code <= 2'd0;
        end else begin
            if (launch) tgt_q <= next_code;
            // First step: clock on / reset on
            if (ph_lead) begin
                if (clk_wanted(tgt_q))  clk_en   <= 1'b1;
                if (hold_wanted(tgt_q)) rst_hold <= 1'b1;
            end
            // Second step: reset off / clock off
            if (ph_trail) begin
                if (!hold_wanted(tgt_q)) rst_hold <= 1'b0;
                if (!clk_wanted(tgt_q))  clk_en   <= 1'b0;
            end
            if (commit) cur_code <= tgt_q;
        end
    end

    // R6: reset is released only when the clock was already running
    p_clock_before_release_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_hold) |-> (clk_en && $past(clk_en)));

    // R7: the clock is gated only when reset was already held
    p_hold_before_gate_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en) |-> (rst_hold && $past(rst_hold)));

    // R1: when idle, the outputs agree with the reported state
    p_status_match_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (clk_en == cur_code[0] && rst_hold == !cur_code[1]));

    // R3: while idle, the outputs do not move
    p_idle_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> ($stable(clk_en) && $stable(rst_hold)));

endmodule

// File: rtl/modclk_ctrl.sv
module modclk_ctrl
    import mcr_pkg::*;
#(
    parameter int MOD_CNT  = 4,
    parameter int STEP_CYC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [MOD_CNT-1:0] mod_clk_en,
    output logic [MOD_CNT-1:0] mod_rst_hold
);

    localparam int FLAT_W = 2 * MOD_CNT;

    logic              go_req, launch, ph_lead, ph_trail, commit, busy;
    logic [FLAT_W-1:0] next_flat, cur_flat;

    initial begin
        if (MOD_CNT < 1 || MOD_CNT > 16) $error("MOD_CNT must be 1..16");
        if (STEP_CYC < 1) $error("STEP_CYC must be at least 1");
    end

    mcr_regs #(.MOD_CNT(MOD_CNT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .cur_flat  (cur_flat),
        .bus_rdata (bus_rdata),
        .next_flat (next_flat),
        .go_req    (go_req)
    );

    mcr_seq #(.STEP_CYC(STEP_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go_req   (go_req),
        .launch   (launch),
        .ph_lead  (ph_lead),
        .ph_trail (ph_trail),
        .commit   (commit),
        .busy     (busy)
    );

    for (genvar i = 0; i < MOD_CNT; i++) begin : g_lane
        mcr_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .launch    (launch),
            .ph_lead   (ph_lead),
            .ph_trail  (ph_trail),
            .commit    (commit),
            .busy      (busy),
            .next_code (next_flat[2*i +: 2]),
            .clk_en    (mod_clk_en[i]),
            .rst_hold  (mod_rst_hold[i]),
            .cur_code  (cur_flat[2*i +: 2])
        );
    end

endmodule

// File: tb/modclk_ctrl_tb.sv
module modclk_ctrl_tb;

    localparam int NM   = 4;
    localparam int STEP = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NM-1:0] mod_clk_en, mod_rst_hold;

    int n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    modclk_ctrl #(.MOD_CNT(NM), .STEP_CYC(STEP)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .mod_clk_en   (mod_clk_en),
        .mod_rst_hold (mod_rst_hold)
    );

    // Behavioural reference model
    int            m_next [NM];
    int            m_keep [NM];
    int            m_cur  [NM];
    int            m_tgt  [NM];
    logic [NM-1:0] m_clk, m_hold;
    bit            m_busy;
    int            m_t;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NM; i++) begin
                m_next[i] = 0; m_keep[i] = 0; m_cur[i] = 0; m_tgt[i] = 0;
            end
            m_clk = '0; m_hold = '1; m_busy = 0; m_t = 0;
        end else begin
            if (m_busy) begin
                m_t++;
                if (m_t == 1) begin
                    for (int i = 0; i < NM; i++) begin
                        if (m_tgt[i] == 1 || m_tgt[i] == 3) m_clk[i] = 1'b1;
                        if (m_tgt[i] != 3) m_hold[i] = 1'b1;
                    end
                end
                if (m_t == 1 + STEP) begin
                    for (int i = 0; i < NM; i++) begin
                        if (m_tgt[i] == 3) m_hold[i] = 1'b0;
                        if (m_tgt[i] == 0) m_clk[i] = 1'b0;
                    end
                end
                if (m_t == 2 + STEP) begin
                    for (int i = 0; i < NM; i++) m_cur[i] = m_tgt[i];
                    m_busy = 0;
                end
            end else if (bus_sel && bus_we && bus_addr == 8'h00 && bus_wdata[0]) begin
                m_busy = 1; m_t = 0;
                for (int i = 0; i < NM; i++) m_tgt[i] = m_next[i];
            end
            if (bus_sel && bus_we && bus_addr[7:6] == 2'd1 && int'(bus_addr[5:2]) < NM) begin
                if (bus_wdata[1:0] != 2'd2) m_next[bus_addr[5:2]] = int'(bus_wdata[1:0]);
                m_keep[bus_addr[5:2]] = int'(bus_wdata[9]);
            end
        end
    end

    // Per-cycle output comparison
    always @(negedge clk) begin
        if (!rst) begin
            n_cmp++;
            if (mod_clk_en !== m_clk || mod_rst_hold !== m_hold) begin
                n_bad++;
                $display("FAIL R1/R6/R7 outputs: clk_en %b hold %b, expected %b %b at %0t",
                         mod_clk_en, mod_rst_hold, m_clk, m_hold, $time);
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int idx = int'(a[5:2]);
        case (a[7:6])
            2'd0:    return (idx == 1) ? 32'(m_busy) : 32'd0;
            2'd1:    return (idx < NM) ? 32'(m_next[idx] | (m_keep[idx] << 9)) : 32'd0;
            2'd2:    return (idx < NM) ? 32'(m_cur[idx]) : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic do_read(input logic [7:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        e = exp_read(a);
        n_cmp++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", tag, a, bus_rdata, e);
        end
        bus_sel = 1'b0;
    endtask

    task automatic poll_busy(input int n, input string tag);
        for (int k = 0; k < n; k++) do_read(8'h04, tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < NM; i++) begin
            do_read(8'(8'h40 + 4 * i), tag);
            do_read(8'(8'h80 + 4 * i), tag);
        end
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        do_read(8'h04, "R11");
        read_all("R11");

        // R3: staging only; R8 / R2: flag bit stored and read back
        do_write(8'h40, 32'h3);
        do_write(8'h44, 32'h1);
        do_write(8'h48, 32'h203);
        repeat (4) @(negedge clk);
        read_all("R3 R8 R2");

        // R13: go bit clear starts nothing
        do_write(8'h00, 32'h2);
        poll_busy(3, "R13");

        // R4 R5 R6: commit upward; R10: second go while busy
        do_write(8'h00, 32'h1);
        do_write(8'h00, 32'h1);
        poll_busy(6, "R5 R10");
        read_all("R4 R5 R1");

        // R7: downward and sideways moves; R8 read-modify-write keeps bit 9
        do_write(8'h40, 32'h0);
        do_write(8'h44, 32'h3);
        do_write(8'h48, 32'h201);
        do_write(8'h00, 32'h1);
        poll_busy(6, "R5 R7");
        read_all("R7 R1 R8");

        // R9: out-of-range indices
        do_write(8'h54, 32'h203);
        do_write(8'h7C, 32'h3);
        do_read(8'h54, "R9");
        do_read(8'h94, "R9");
        read_all("R9");
        do_write(8'h00, 32'h1);
        poll_busy(6, "R9");

        // R12: illegal code keeps the next state, bit 9 still written
        do_write(8'h4C, 32'h3);
        do_write(8'h4C, 32'h202);
        do_read(8'h4C, "R12");
        do_write(8'h00, 32'h1);
        poll_busy(6, "R12 R6");
        read_all("R12 R1");

        // Everything back down
        for (int i = 0; i < NM; i++) do_write(8'(8'h40 + 4 * i), 32'h0);
        do_write(8'h00, 32'h1);
        poll_busy(6, "R7 R5");
        read_all("R7 R1");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule